// File: doc/BRIEF.md
# In-Band Loop Code Generator

This block sits on the serial transmit bit stream of a T1 line and replaces the payload with a repeating in-band loopback code. Two codes are supported. The loop-up code activates a remote loopback and the loop-down code releases it. Each code is either a fixed built-in pattern or a pattern written by the user, 5 to 8 bits long. The framer sends one bit per bit-enable pulse. It also raises a frame-bit strobe when the current bit sits in the frame bit position.

In unframed insertion every bit slot carries the code. In framed insertion the frame bit slot carries the framer's own bit, and the code sequence waits there. Once a request arrives, the code stays on the line for at least five ticks of an external one-second pulse. If the request is still held after that, the code continues for as long as it is held. When the block is not sending, it passes the input data through unchanged.

Top module: `inband_loop_gen`

## Requirements
- R1: After reset, `data_out` is 0 and `active` is 0.
- R2: While `active` is 0, each cycle with `bit_en` high loads `data_in` into `data_out`, and the new value is visible in the next cycle.
- R3: The built-in loop-up code is the 5-bit pattern 00001 and the built-in loop-down code is the 3-bit pattern 001. Each repeats without gaps, and the first bit after a start is the first bit of the pattern.
- R4: With `user_pat_en` high, a code's pattern is taken from its 8-bit register. Its length is 5 plus the code's 2-bit length field (0 gives 5 bits, 3 gives 8 bits). Bits go out from bit position length-1 down to bit 0, then the pattern wraps.
- R5: With `framed_mode` high, a bit slot flagged by `frame_bit` outputs `data_in`, and the code does not advance in that slot.
- R6: With `framed_mode` low, a slot flagged by `frame_bit` carries the next code bit like any other slot.
- R7: A rising edge on the combined request (`req_up` or `req_dn`) sets `active` in the next cycle. If the requests are dropped before five `sec_tick` pulses have been counted, `active` stays high until the fifth pulse has been counted, and it clears two cycles after that pulse.
- R8: While a request is held, `active` stays high even after five ticks. It clears one cycle after the request drops, provided five ticks have already been counted.
- R9: When both requests are high, the loop-down code is sent. When the selected code changes, the pattern restarts at its first bit.
- R10: In cycles with `bit_en` low, `data_out` holds its value and the code position does not advance.
- R11: A new rising edge of the combined request while a code is already being sent restarts both the five-tick count and the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One pulse per transmit bit slot |
| frame_bit | input | 1 | Current slot is the frame bit position |
| data_in | input | 1 | Serial data from the framer |
| sec_tick | input | 1 | One-cycle pulse each second |
| req_up | input | 1 | Request to send the loop-up code |
| req_dn | input | 1 | Request to send the loop-down code |
| framed_mode | input | 1 | 1: leave frame bit slots to the framer |
| user_pat_en | input | 1 | 1: use the programmed patterns |
| up_pat | input | 8 | Programmed loop-up pattern |
| dn_pat | input | 8 | Programmed loop-down pattern |
| up_len | input | 2 | Loop-up length field (length = 5 + value) |
| dn_len | input | 2 | Loop-down length field (length = 5 + value) |
| data_out | output | 1 | Serial transmit data |
| active | output | 1 | A loop code is being sent |

## Verification
A bit offered with `bit_en` appears on `data_out` one cycle later. A request edge sets `active` one cycle later. After the fifth tick the count is registered one cycle later, so `active` clears in the following cycle. The bench drives inputs on the falling edge and samples outputs on the falling edge after the rising edge that produces them. A behavioural model advances on the same rising edges and is compared with both outputs every cycle. Directed sequences check the expected bit patterns for each code, length and insertion mode, and check when `active` falls after ticks or after a dropped request.

// File: rtl/ilg_pkg.sv
package ilg_pkg;
  // Selected code
  typedef enum logic {
    CODE_UP = 1'b0,
    CODE_DN = 1'b1
  } code_e;

  // Built-in codes: value and length (value right aligned, sent MSB first)
  localparam int unsigned BI_UP_VAL = 1;  // 00001
  localparam int unsigned BI_UP_LEN = 5;
  localparam int unsigned BI_DN_VAL = 1;  // 001
  localparam int unsigned BI_DN_LEN = 3;
endpackage

// File: rtl/ilg_ctrl.sv
// Request tracking, code selection and minimum-duration timer.
module ilg_ctrl
  import ilg_pkg::*;
#(
  parameter int unsigned MIN_SECS = 5,
  localparam int unsigned CW = $clog2(MIN_SECS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_up,
  input  logic          req_dn,
  input  logic          sec_tick,
  output logic          active,
  output code_e         sel,
  output logic          restart,
  output logic [CW-1:0] sec_cnt
);
  logic          req_any;
  logic          req_q, req_d;
  logic          act_q, act_d;
  code_e         sel_q, sel_d;
  code_e         want;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          start;
  logic          hold_met;

  always_comb begin
    req_any  = req_up | req_dn;
    want     = req_dn ? CODE_DN : CODE_UP;   // loop-down wins
    start    = req_any & ~req_q;
    hold_met = (cnt_q == CW'(MIN_SECS));
    req_d    = req_any;

    act_d = act_q;
    if (start)
      act_d = 1'b1;
    else if (act_q && !req_any && hold_met)
      act_d = 1'b0;

    cnt_d = cnt_q;
    if (start)
      cnt_d = '0;
    else if (act_q && sec_tick && !hold_met)
      cnt_d = cnt_q + CW'(1);

    sel_d   = req_any ? want : sel_q;
    restart = start | (req_any & (want != sel_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      act_q <= 1'b0;
      sel_q <= CODE_UP;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      act_q <= act_d;
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  assign active  = act_q;
  assign sel     = sel_q;
  assign sec_cnt = cnt_q;
endmodule

// File: rtl/ilg_pat_sel.sv
// Picks the pattern word and its length for the selected code.
module ilg_pat_sel
  import ilg_pkg::*;
#(
  parameter int unsigned PAT_W    = 8,
  parameter int unsigned LEN_FW   = 2,
  parameter int unsigned MIN_LEN  = 5,
  parameter bit          HAS_USER = 1'b1,
  localparam int unsigned LW      = $clog2(PAT_W + 1)
) (
  input  code_e             sel,
  input  logic              user_pat_en,
  input  logic [PAT_W-1:0]  up_pat,
  input  logic [PAT_W-1:0]  dn_pat,
  input  logic [LEN_FW-1:0] up_len,
  input  logic [LEN_FW-1:0] dn_len,
  output logic [PAT_W-1:0]  pat,
  output logic [LW-1:0]     plen
);
  logic [PAT_W-1:0] bi_pat;
  logic [LW-1:0]    bi_len;

  always_comb begin
    if (sel == CODE_DN) begin
      bi_pat = PAT_W'(BI_DN_VAL);
      bi_len = LW'(BI_DN_LEN);
    end else begin
      bi_pat = PAT_W'(BI_UP_VAL);
      bi_len = LW'(BI_UP_LEN);
    end
  end

  generate
    if (HAS_USER) begin : g_user
      logic [PAT_W-1:0]  u_pat;
      logic [LEN_FW-1:0] u_fld;
      always_comb begin
        u_pat = (sel == CODE_DN) ? dn_pat : up_pat;
        u_fld = (sel == CODE_DN) ? dn_len : up_len;
        if (user_pat_en) begin
          pat  = u_pat;
          plen = LW'(MIN_LEN) + LW'(u_fld);
        end else begin
          pat  = bi_pat;
          plen = bi_len;
        end
      end
    end else begin : g_fixed
      logic unused_ok;
      assign unused_ok = ^{user_pat_en, up_pat, dn_pat, up_len, dn_len};
      assign pat  = bi_pat;
      assign plen = bi_len;
    end
  endgenerate
endmodule

// File: rtl/ilg_serializer.sv
// Bit pointer and output register: code bits or pass-through per slot.
module ilg_serializer #(
  parameter int unsigned PAT_W = 8,
  localparam int unsigned LW   = $clog2(PAT_W + 1),
  localparam int unsigned IW   = (PAT_W > 1) ? $clog2(PAT_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             frame_bit,
  input  logic             data_in,
  input  logic             framed_mode,
  input  logic             active,
  input  logic             restart,
  input  logic [PAT_W-1:0] pat,
  input  logic [LW-1:0]    plen,
  output logic             data_out
);
  logic [IW-1:0] ptr_q, ptr_d;
  logic          dout_q, dout_d;
  logic          take;
  logic [LW-1:0] eff;
  logic [LW-1:0] nxt;
  logic [LW-1:0] idx;
  logic          pbit;

  always_comb begin
    // slot carries a code bit unless framed mode reserves the frame bit
    take = bit_en & active & ~(framed_mode & frame_bit);
    eff  = (LW'(ptr_q) < plen) ? LW'(ptr_q) : '0;
    idx  = plen - LW'(1) - eff;
    pbit = pat[idx[IW-1:0]];
    nxt  = eff + LW'(1);

    ptr_d = ptr_q;
    if (restart)
      ptr_d = '0;
    else if (take)
      ptr_d = (nxt >= plen) ? '0 : nxt[IW-1:0];

    dout_d = dout_q;
    if (bit_en)
      dout_d = take ? pbit : data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      dout_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      dout_q <= dout_d;
    end
  end

  assign data_out = dout_q;
endmodule

// File: rtl/inband_loop_gen.sv
// Top: in-band loop code insertion on a serial transmit stream.
module inband_loop_gen
  import ilg_pkg::*;
#(
  parameter int unsigned PAT_W    = 8,
  parameter int unsigned LEN_FW   = 2,
  parameter int unsigned MIN_LEN  = 5,
  parameter int unsigned MIN_SECS = 5,
  parameter bit          HAS_USER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_bit,
  input  logic              data_in,
  input  logic              sec_tick,
  input  logic              req_up,
  input  logic              req_dn,
  input  logic              framed_mode,
  input  logic              user_pat_en,
  input  logic [PAT_W-1:0]  up_pat,
  input  logic [PAT_W-1:0]  dn_pat,
  input  logic [LEN_FW-1:0] up_len,
  input  logic [LEN_FW-1:0] dn_len,
  output logic              data_out,
  output logic              active
);
  localparam int unsigned LW = $clog2(PAT_W + 1);
  localparam int unsigned CW = $clog2(MIN_SECS + 1);

  code_e            sel;
  logic             restart;
  logic [CW-1:0]    sec_cnt;
  logic [PAT_W-1:0] pat;
  logic [LW-1:0]    plen;

  ilg_ctrl #(.MIN_SECS(MIN_SECS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_up   (req_up),
    .req_dn   (req_dn),
    .sec_tick (sec_tick),
    .active   (active),
    .sel      (sel),
    .restart  (restart),
    .sec_cnt  (sec_cnt)
  );

  ilg_pat_sel #(
    .PAT_W(PAT_W), .LEN_FW(LEN_FW), .MIN_LEN(MIN_LEN), .HAS_USER(HAS_USER)
  ) u_pat (
    .sel         (sel),
    .user_pat_en (user_pat_en),
    .up_pat      (up_pat),
    .dn_pat      (dn_pat),
    .up_len      (up_len),
    .dn_len      (dn_len),
    .pat         (pat),
    .plen        (plen)
  );

  ilg_serializer #(.PAT_W(PAT_W)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .frame_bit   (frame_bit),
    .data_in     (data_in),
    .framed_mode (framed_mode),
    .active      (active),
    .restart     (restart),
    .pat         (pat),
    .plen        (plen),
    .data_out    (data_out)
  );
endmodule

// File: rtl/ilg_chk.sv
// Property checker, bound into the top module.
module ilg_chk #(
  parameter int unsigned MIN_SECS = 5,
  parameter int unsigned CW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          frame_bit,
  input logic          data_in,
  input logic          framed_mode,
  input logic          req_up,
  input logic          req_dn,
  input logic          data_out,
  input logic          active,
  input logic          sel_dn,
  input logic [CW-1:0] sec_cnt
);
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(data_out)); // R10
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !active) |=> (data_out == $past(data_in))); // R2
  AST_FRAME_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && active && framed_mode && frame_bit) |=> (data_out == $past(data_in))); // R5
  AST_START_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_up || req_dn) |=> active); // R7
  AST_HELD_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (req_up || req_dn)) |=> active); // R8
  AST_DN_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    req_dn |=> sel_dn); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sec_cnt) <= MIN_SECS)); // R7
endmodule

bind inband_loop_gen ilg_chk #(.MIN_SECS(MIN_SECS), .CW(CW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_en      (bit_en),
  .frame_bit   (frame_bit),
  .data_in     (data_in),
  .framed_mode (framed_mode),
  .req_up      (req_up),
  .req_dn      (req_dn),
  .data_out    (data_out),
  .active      (active),
  .sel_dn      (sel == ilg_pkg::CODE_DN),
  .sec_cnt     (sec_cnt)
);

// File: tb/inband_loop_gen_tb_top.sv
`timescale 1ns/1ps
module inband_loop_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, frame_bit = 1'b0, data_in = 1'b0, sec_tick = 1'b0;
  logic       req_up = 1'b0, req_dn = 1'b0, framed_mode = 1'b0, user_pat_en = 1'b0;
  logic [7:0] up_pat = 8'h00, dn_pat = 8'h00;
  logic [1:0] up_len = 2'd0, dn_len = 2'd0;
  logic       data_out, active;

  int    n_cmp = 0, n_bad = 0, cycles = 0;
  bit    done = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  inband_loop_gen dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_bit(frame_bit),
    .data_in(data_in), .sec_tick(sec_tick), .req_up(req_up), .req_dn(req_dn),
    .framed_mode(framed_mode), .user_pat_en(user_pat_en), .up_pat(up_pat),
    .dn_pat(dn_pat), .up_len(up_len), .dn_len(dn_len),
    .data_out(data_out), .active(active)
  );

  // ---------------- behavioural reference ----------------
  bit m_act, m_dn, m_rq, m_out;
  int m_cnt, m_pos;

  function automatic int code_len(bit dn);
    if (user_pat_en) return 5 + int'(dn ? dn_len : up_len);
    return dn ? 3 : 5;
  endfunction

  function automatic bit code_bit(bit dn, int p);
    int v;
    int n;
    n = code_len(dn);
    v = user_pat_en ? int'(dn ? dn_pat : up_pat) : 1;
    return bit'((v >> (n - 1 - p)) & 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_dn = 0; m_rq = 0; m_out = 0; m_cnt = 0; m_pos = 0;
    end else begin
      bit any, rise, send, nd, na;
      int p, n, nc, np;
      any  = req_up || req_dn;
      rise = any && !m_rq;
      n    = code_len(m_dn);
      p    = (m_pos < n) ? m_pos : 0;
      send = bit_en && m_act && !(framed_mode && frame_bit);
      if (bit_en) m_out = send ? code_bit(m_dn, p) : data_in;
      np = send ? (p + 1) % n : m_pos;
      if (rise || (any && (req_dn != m_dn))) np = 0;
      nd = any ? req_dn : m_dn;
      na = m_act; nc = m_cnt;
      if (rise) begin na = 1; nc = 0; end
      else begin
        if (m_act && !any && m_cnt == 5) na = 0;
        if (m_act && sec_tick && m_cnt < 5) nc = m_cnt + 1;
      end
      m_act = na; m_cnt = nc; m_pos = np; m_dn = nd; m_rq = any;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      n_cmp++;
      if (data_out !== m_out || active !== m_act) begin
        n_bad++;
        $display("FAIL %s model: data_out=%b active=%b expected data_out=%b active=%b",
                 tag, data_out, active, m_out, m_act);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic check(string req, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(logic d, logic fb, output logic got);
    @(negedge clk); bit_en = 1; data_in = d; frame_bit = fb;
    @(negedge clk); bit_en = 0; frame_bit = 0; got = data_out;
  endtask

  task automatic expect_seq(string req, string s, logic d, logic fb);
    logic g;
    for (int i = 0; i < s.len(); i++) begin
      send(d, fb, g);
      check(req, g, (s[i] == "1"));
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_tick = 1;
      @(negedge clk); sec_tick = 0;
    end
  endtask

  task automatic stop_code();
    @(negedge clk); req_up = 0; req_dn = 0;
    tick(5); idle(3);
    check("R7", active, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic g;
    idle(3);
    check("R1", data_out, 1'b0);
    check("R1", active, 1'b0);
    @(negedge clk); rst_n = 1;
    idle(2);

    tag = "R2";
    send(1, 0, g); check("R2", g, 1'b1);
    send(0, 0, g); check("R2", g, 1'b0);
    send(1, 1, g); check("R2", g, 1'b1);

    // built-in loop-up, unframed; frame slot overwritten
    tag = "R3";
    @(negedge clk); req_up = 1;
    @(negedge clk);
    check("R7", active, 1'b1);
    expect_seq("R3", "0000100001", 1, 0);
    tag = "R6";
    send(1, 1, g); check("R6", g, 1'b0);
    expect_seq("R6", "0001", 1, 1);
    tag = "R10";
    idle(4); check("R10", data_out, 1'b1);
    stop_code();

    // framed insertion
    tag = "R5";
    framed_mode = 1;
    @(negedge clk); req_up = 1; @(negedge clk);
    expect_seq("R5", "00", 1, 0);
    send(1, 1, g); check("R5", g, 1'b1);
    send(0, 1, g); check("R5", g, 1'b0);
    expect_seq("R5", "001", 0, 0);
    stop_code();
    framed_mode = 0;

    // priority and code change
    tag = "R9";
    @(negedge clk); req_up = 1; req_dn = 1; @(negedge clk);
    expect_seq("R9", "00100", 1, 0);
    @(negedge clk); req_dn = 0; @(negedge clk);
    expect_seq("R9", "000010", 1, 0);
    stop_code();

    // user patterns
    tag = "R4";
    user_pat_en = 1; up_pat = 8'b1011_0011; up_len = 2'd2;
    dn_pat = 8'hA5; dn_len = 2'd0;
    @(negedge clk); req_up = 1; @(negedge clk);
    expect_seq("R4", "01100110", 0, 0);
    stop_code();
    up_len = 2'd3;
    @(negedge clk); req_up = 1; @(negedge clk);
    expect_seq("R4", "101100111", 0, 0);
    stop_code();
    @(negedge clk); req_dn = 1; @(negedge clk);
    expect_seq("R4", "001010", 1, 0);
    stop_code();
    user_pat_en = 0;

    // minimum duration after early drop
    tag = "R7";
    @(negedge clk); req_up = 1; @(negedge clk);
    tick(2);
    @(negedge clk); req_up = 0; idle(3);
    check("R7", active, 1'b1);
    tick(2); idle(3);
    check("R7", active, 1'b1);
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    check("R7", active, 1'b1);
    @(negedge clk);
    check("R7", active, 1'b0);

    // held request
    tag = "R8";
    @(negedge clk); req_dn = 1; @(negedge clk);
    tick(7); idle(3);
    check("R8", active, 1'b1);
    @(negedge clk); req_dn = 0;
    @(negedge clk);
    check("R8", active, 1'b0);

    // re-request restarts the count
    tag = "R11";
    @(negedge clk); req_up = 1; @(negedge clk);
    tick(3);
    @(negedge clk); req_up = 0;
    @(negedge clk); req_up = 1;
    @(negedge clk); req_up = 0;
    expect_seq("R11", "000", 1, 0);
    tick(4); idle(3);
    check("R11", active, 1'b1);
    tick(1); idle(3);
    check("R11", active, 1'b0);

    tag = "R2";
    send(1, 0, g); check("R2", g, 1'b1);
    idle(3);
    finish_run();
  end
endmodule